// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block holds the digital side of an 8-bit successive-approximation converter with a serial interface. A host selects the block by pulling `cs_n` low and clocks a command in on `din`. The command is a 1 start bit, a mode bit, an odd/sign bit and a parameter-set number of channel-select bits. The block reports the decoded mode and channel to the analog multiplexer, waits one clock for the sample window to settle, and then steps through the approximation. On each step it presents a trial code to an external DAC and reads back one comparator decision.

Each decided bit leaves on `dout` on the falling clock edge after the rising edge that resolved it, so the word appears MSB first while conversion runs. Unless `shift_en` is high, the word is then replayed LSB first. That replay reuses the LSB that has already been sent and continues with bits 1 up to the MSB. Raising `cs_n` at any time stops the cycle, releases both outputs and returns the block to waiting for a start bit.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While `cs_n` is 1, `dout_oe` and `sars_oe` are 0 and all state is cleared. Raising `cs_n` at any point stops the cycle, and the next command after `cs_n` falls is handled from the start.
- R2: `din` is sampled on rising `clk` edges. Zeros before the first 1 are ignored, and the first 1 is taken as the start bit.
- R3: The three fields follow the start bit in this order: a mode bit (1 means single-ended, shown on `is_single`), then the odd/sign bit, then `NSEL` select bits sent most significant first. `chan_idx` is {select bits, odd/sign bit}, so the odd/sign bit is its LSB.
- R4: After the last address bit, `din` is ignored until `cs_n` goes high. `is_single` and `chan_idx` hold their values.
- R5: Exactly one settle clock follows the last address bit. During it `sars` is 0 and `dout` is 0.
- R6: `sars` is 1 from the rising edge that ends the settle clock until the rising edge that resolves bit 0. This is exactly `RES_W` clocks.
- R7: During a trial, `dac_code` holds the bits already kept plus a 1 in the bit under test, with all lower bits 0. The bit is kept when `cmp_hi` is 1 (input at or above the DAC level). After the conversion, `dac_code` holds the final word. For an input equal to a code value, this word equals that code.
- R8: `dout` changes only on falling `clk` edges. Result bits appear MSB first, each on the falling edge after the rising edge that resolved it.
- R9: With `shift_en` = 0 at the rising edge that resolves bit 0, bits 1 through `RES_W`-1 follow on the next falling edges. After them `dout` is 0.
- R10: With `shift_en` = 1 at that edge, no replay is sent, and `dout` is 0 from the next falling edge on.
- R11: Once the output stream is complete, `sars` and `dout` stay 0 until `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; `din` is taken on the rising edge, `dout` changes on the falling edge |
| cs_n | input | 1 | Active-low select; high clears all state and acts as the asynchronous reset |
| din | input | 1 | Serial command input |
| shift_en | input | 1 | 1 suppresses the LSB-first replay |
| cmp_hi | input | 1 | Comparator decision: input at or above the DAC level |
| dout | output | 1 | Serial result |
| dout_oe | output | 1 | Output enable for `dout` |
| sars | output | 1 | Conversion in progress |
| sars_oe | output | 1 | Output enable for `sars` |
| dac_code | output | RES_W | Trial code to the DAC, and the final word once the conversion is done |
| is_single | output | 1 | Decoded mode bit |
| chan_idx | output | NSEL+1 | Decoded channel index |

## Verification
The sweep converts every input code from 0 to 255 while varying the mode, odd/sign bit, select bits, replay option and the number of leading zeros. Toggling `din` during conversion shows whether the block ignores it; a design that keeps listening would change the channel outputs or restart. The bench samples `dout` just after the rising edge as well as after the falling edge, so an output register on the wrong edge shows bits half a clock early. An off-by-one in the replay would repeat or drop the shared LSB or leave junk after bit 7. A mis-timed settle clock would shift every bit by one place. Two aborts, one during the address and one during the approximation, are followed by a clean conversion, which shows whether any state survives.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {RX_WAIT, RX_ADDR, RX_DONE} rx_phase_e;
   typedef enum logic [1:0] {PH_IDLE, PH_CONV, PH_TAIL, PH_DONE} sar_phase_e;
endpackage

// File: rtl/sar_cmd_rx.sv
module sar_cmd_rx
   import sar_seq_pkg::*;
#(
   parameter int NSEL = 2
) (
   input  logic          clk,
   input  logic          cs_n,
   input  logic          din,
   output logic          cmd_done,
   output logic          is_single,
   output logic [NSEL:0] chan_idx
);
   localparam int ADDR_BITS = NSEL + 2;
   localparam int CNT_W     = (ADDR_BITS > 2) ? $clog2(ADDR_BITS) : 1;

   rx_phase_e              phase;
   logic [CNT_W-1:0]       cnt;
   logic [ADDR_BITS-1:0]   shreg;

   always_ff @(posedge clk or posedge cs_n) begin
      if (cs_n) begin
         phase <= RX_WAIT;
         cnt   <= '0;
         shreg <= '0;
      end else begin
         case (phase)
            RX_WAIT: if (din) begin
               phase <= RX_ADDR;
               cnt   <= '0;
            end
            RX_ADDR: begin
               shreg <= {shreg[ADDR_BITS-2:0], din};
               if (cnt == CNT_W'(ADDR_BITS - 1)) phase <= RX_DONE;
               else                              cnt   <= cnt + CNT_W'(1);
            end
            default: ;
         endcase
      end
   end

   assign cmd_done  = (phase == RX_DONE);
   assign is_single = shreg[ADDR_BITS-1];

   generate
      if (NSEL == 0) begin : g_no_sel
         assign chan_idx = shreg[0];
      end else begin : g_sel
         assign chan_idx = {shreg[NSEL-1:0], shreg[NSEL]};
      end
   endgenerate

   // R2: a low din while waiting never leaves the wait state
   p_wait_start_r2: assert property (@(posedge clk) disable iff (cs_n)
      (phase == RX_WAIT && !din) |=> (phase == RX_WAIT));

   // R4: once the address is in, it is frozen
   p_hold_addr_r4: assert property (@(posedge clk) disable iff (cs_n)
      (phase == RX_DONE) |=> (phase == RX_DONE && $stable(shreg)));
endmodule

// File: rtl/sar_approx.sv
module sar_approx
   import sar_seq_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             cs_n,
   input  logic             cmd_done,
   input  logic             cmp_hi,
   input  logic             shift_en,
   output logic             sars,
   output logic [RES_W-1:0] dac_code,
   output logic             tx_bit
);
   localparam int STEP_W = $clog2(RES_W);

   sar_phase_e          phase;
   logic [STEP_W-1:0]   step;
   logic [RES_W-1:0]    result;
   logic [RES_W-1:0]    trial_bit;

   assign trial_bit = RES_W'(1) << step;
   assign dac_code  = (phase == PH_CONV) ? (result | trial_bit) : result;
   assign sars      = (phase == PH_CONV);

   always_ff @(posedge clk or posedge cs_n) begin
      if (cs_n) begin
         phase  <= PH_IDLE;
         step   <= '0;
         result <= '0;
         tx_bit <= 1'b0;
      end else begin
         tx_bit <= 1'b0;
         case (phase)
            PH_IDLE: if (cmd_done) begin
               phase  <= PH_CONV;
               step   <= STEP_W'(RES_W - 1);
               result <= '0;
            end
            PH_CONV: begin
               result[step] <= cmp_hi;
               tx_bit       <= cmp_hi;
               if (step == '0) begin
                  if (shift_en) phase <= PH_DONE;
                  else begin
                     phase <= PH_TAIL;
                     step  <= STEP_W'(1);
                  end
               end else begin
                  step <= step - STEP_W'(1);
               end
            end
            PH_TAIL: begin
               tx_bit <= result[step];
               if (step == STEP_W'(RES_W - 1)) phase <= PH_DONE;
               else                            step  <= step + STEP_W'(1);
            end
            default: ;
         endcase
      end
   end

   // R7: the trial bit is set and everything below it is clear
   p_trial_shape_r7: assert property (@(posedge clk) disable iff (cs_n)
      sars |-> (dac_code[step] && ((dac_code & (trial_bit - RES_W'(1))) == '0)));

   // R7: a high decision keeps the trial code, a low one drops below it
   p_keep_r7: assert property (@(posedge clk) disable iff (cs_n)
      (sars && cmp_hi) |=> (result == $past(dac_code)));
   p_drop_r7: assert property (@(posedge clk) disable iff (cs_n)
      (sars && !cmp_hi) |=> (result < $past(dac_code)));

   // R6: conversion ends only after the bit-0 step
   p_sars_end_r6: assert property (@(posedge clk) disable iff (cs_n)
      $fell(sars) |-> ($past(step) == '0));

   // R9: the replay starts at bit 1, the LSB being shared
   p_lsb_shared_r9: assert property (@(posedge clk) disable iff (cs_n)
      (phase == PH_TAIL && $past(phase) == PH_CONV) |-> (step == STEP_W'(1)));

   // R11: nothing is active after the stream
   p_quiet_r11: assert property (@(posedge clk) disable iff (cs_n)
      (phase == PH_DONE) |=> (!sars && !tx_bit));
endmodule

// File: rtl/sar_dout_stage.sv
module sar_dout_stage (
   input  logic clk,
   input  logic cs_n,
   input  logic tx_bit,
   output logic dout
);
   always_ff @(negedge clk or posedge cs_n) begin
      if (cs_n) dout <= 1'b0;
      else      dout <= tx_bit;
   end

   // R8: by each rising edge dout carries the bit chosen at the previous one
   p_dout_follows_r8: assert property (@(posedge clk) disable iff (cs_n)
      dout == tx_bit);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
   parameter int NSEL  = 2,
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             cs_n,
   input  logic             din,
   input  logic             shift_en,
   input  logic             cmp_hi,
   output logic             dout,
   output logic             dout_oe,
   output logic             sars,
   output logic             sars_oe,
   output logic [RES_W-1:0] dac_code,
   output logic             is_single,
   output logic [NSEL:0]    chan_idx
);
   generate
      if (NSEL < 0 || NSEL > 3) begin : g_bad_nsel
         $error("sar_seq_ctrl: NSEL must be 0 to 3");
      end
      if (RES_W < 2 || RES_W > 16) begin : g_bad_width
         $error("sar_seq_ctrl: RES_W must be 2 to 16");
      end
   endgenerate

   logic cmd_done;
   logic tx_bit;

   sar_cmd_rx #(.NSEL(NSEL)) i_rx (
      .clk       (clk),
      .cs_n      (cs_n),
      .din       (din),
      .cmd_done  (cmd_done),
      .is_single (is_single),
      .chan_idx  (chan_idx)
   );

   sar_approx #(.RES_W(RES_W)) i_approx (
      .clk      (clk),
      .cs_n     (cs_n),
      .cmd_done (cmd_done),
      .cmp_hi   (cmp_hi),
      .shift_en (shift_en),
      .sars     (sars),
      .dac_code (dac_code),
      .tx_bit   (tx_bit)
   );

   sar_dout_stage i_dout (
      .clk    (clk),
      .cs_n   (cs_n),
      .tx_bit (tx_bit),
      .dout   (dout)
   );

   assign dout_oe = !cs_n;
   assign sars_oe = !cs_n;

   // R5: the settle clock follows the command with conversion still off
   p_settle_r5: assert property (@(posedge clk) disable iff (cs_n)
      $rose(cmd_done) |-> (!sars && !dout));
endmodule

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/100ps
module test_sar_seq_ctrl;
   logic       clk = 1'b0;
   logic       cs_n = 1'b1;
   logic       din = 1'b0;
   logic       shift_en = 1'b0;
   logic [7:0] vin = '0;
   logic       cmp_hi;
   logic       dout, dout_oe, sars, sars_oe, is_single;
   logic [7:0] dac_code;
   logic [2:0] chan_idx;
   int         total = 0;
   int         bad = 0;

   always #2.5 clk = ~clk;

   assign cmp_hi = (vin >= dac_code);

   sar_seq_ctrl #(.NSEL(2), .RES_W(8)) i_sar_seq_ctrl (
      .clk(clk), .cs_n(cs_n), .din(din), .shift_en(shift_en), .cmp_hi(cmp_hi),
      .dout(dout), .dout_oe(dout_oe), .sars(sars), .sars_oe(sars_oe),
      .dac_code(dac_code), .is_single(is_single), .chan_idx(chan_idx)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic d);
      din = d;
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic run_conv(input logic [7:0] v, input logic sg, input logic od,
                           input logic [1:0] sl, input logic se, input int lead);
      logic prev;
      vin = v;
      shift_en = se;
      cs_n = 1'b0;
      #0.5;
      chk("R1 oe while selected", {dout_oe, sars_oe}, 2'b11);
      for (int i = 0; i < lead; i++) begin
         step(1'b0);
         chk("R2 leading zero ignored", {sars, dout}, 2'b00);
      end
      step(1'b1);
      step(sg);
      step(od);
      step(sl[1]);
      step(sl[0]);
      chk("R3 mode bit", is_single, sg);
      chk("R3 channel index", chan_idx, {sl, od});
      chk("R5 settle sars", sars, 1'b0);
      chk("R5 settle dout", dout, 1'b0);
      step(~v[0]);
      chk("R6 sars rises after settle", sars, 1'b1);
      chk("R5 dout low after settle", dout, 1'b0);
      for (int k = 7; k >= 0; k--) begin
         prev = dout;
         din = v[k] ^ sg;
         @(posedge clk);
         #1;
         chk("R8 no change at rising edge", dout, prev);
         @(negedge clk);
         #1;
         chk($sformatf("R7 R8 bit %0d of %0h", k, v), dout, v[k]);
         chk("R6 sars window", sars, (k > 0));
      end
      if (!se) begin
         for (int i = 1; i < 8; i++) begin
            step(v[i]);
            chk($sformatf("R9 replay bit %0d of %0h", i, v), dout, v[i]);
         end
         step(1'b1);
         chk("R9 low after replay", dout, 1'b0);
      end else begin
         step(1'b1);
         chk("R10 no replay", dout, 1'b0);
         step(1'b0);
         chk("R10 still low", dout, 1'b0);
      end
      step(1'b1);
      chk("R11 quiet dout", dout, 1'b0);
      chk("R11 quiet sars", sars, 1'b0);
      chk("R4 mode held", is_single, sg);
      chk("R4 channel held", chan_idx, {sl, od});
      chk("R7 final word", dac_code, v);
      cs_n = 1'b1;
      #0.5;
      chk("R1 released", {dout_oe, sars_oe, sars, dout}, 4'b0000);
      step(1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset state", {dout_oe, sars_oe, sars, dout}, 4'b0000);
      chk("R1 reset dac", dac_code, 8'h00);

      for (int v = 0; v < 256; v++) begin
         run_conv(8'(v), v[0], v[1], 2'(v >> 2), v[4], v % 3);
      end

      // abort during the approximation
      cs_n = 1'b0;
      step(1'b1); step(1'b1); step(1'b0); step(1'b1); step(1'b1);
      step(1'b0);
      step(1'b0); step(1'b1);
      chk("R1 busy before abort", sars, 1'b1);
      cs_n = 1'b1;
      #0.5;
      chk("R1 abort releases", {sars_oe, dout_oe, sars}, 3'b000);
      step(1'b1);
      step(1'b1);
      run_conv(8'h5a, 1'b0, 1'b1, 2'b10, 1'b0, 0);

      // abort during the address
      cs_n = 1'b0;
      step(1'b1); step(1'b1);
      cs_n = 1'b1;
      step(1'b0);
      run_conv(8'hc3, 1'b1, 1'b0, 2'b01, 1'b1, 2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule